// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent down-counters behind one register bus. It also has one shared interrupt block. Each channel counts down once per prescaled tick. It runs in one of three modes: it stops at zero, it reloads from a buffered reload value, or it wraps to all ones. A channel can count over 32 bits or over the low 16 bits only. When a channel's count arrives at zero, its bit in the raw interrupt status is set. The shared block masks the raw bits, lets software clear them, and drives a single interrupt line.

Software writes the load register to start a count at once. It writes the reload register to change the period from the next wrap onward, without disturbing the count in progress. Software sets mode, width, prescaler and enable through the control register. Elapsed time is read as the inverse of the current value, because the counter counts downward.

Each channel is governed by a three-state machine:
- **OFF**: the channel is disabled.
- **COUNT**: the channel is counting.
- **HALT**: a single-shot count has finished.

Its transitions are:
- **start**: OFF to COUNT, on a control write with enable set.
- **stop**: COUNT or HALT to OFF, on a control write with enable clear.
- **expire**: COUNT to HALT, when a single-shot tick finds the count at one or at zero.
- **rearm**: HALT to COUNT, on a load write.

Top module: `quad_timer`

## Requirements
- R1: After reset, every count, reload value, control value, mask bit and raw bit is zero, and `irq` is low.
- R2: The shared registers have these byte offsets:

  | Offset | Register |
  |---|---|
  | 0x00 | interrupt enable mask |
  | 0x04 | raw status |
  | 0x08 | masked status |
  | 0x0C | write-1 clear |

  Bit n of each shared register belongs to channel n. Channel n has a window at 0x10+0x10·n, laid out as follows:

  | Offset in window | Register |
  |---|---|
  | +0x0 | load; reads back the reload value |
  | +0x4 | current value; read only |
  | +0x8 | control; 8 bits, read back as written |
  | +0xC | reload |

  A load write sets both the count and the reload value at once.
- R3: The control bits are as follows:

  | Bit | Function |
  |---|---|
  | 7 | enable |
  | 6 | repeat mode |
  | 3:2 | prescaler code |
  | 1 | 32-bit width |
  | 0 | single-shot |

  Single-shot takes precedence over repeat. With neither bit set, the channel is free-running. A disabled channel holds its count.
- R4: The prescaler divides the tick according to its code:

  | Code | Divide by |
  |---|---|
  | 00 | 1 |
  | 01 | 16 |
  | 10 | 256 |
  | 11 | 256 |

  The prescale counter restarts on every load or control write. The first decrement comes that many clocks after the write.
- R5: A tick that takes the count from one to zero sets the channel's raw status bit.
- R6: In single-shot mode the count stops at zero after exactly one event. It stays there until a load write rearms the channel.
- R7: In repeat mode, the tick after zero loads the reload value, so the period is reload+1 ticks.
- R8: A reload-register write leaves the current count alone. The new value takes effect at the next wrap.
- R9: In free-running mode, the tick after zero wraps the count to all ones of the active width, with no reload.
- R10: With bit 1 clear, only the low 16 bits count. The upper 16 bits of the current value read as zero, and the wrap goes to 0xFFFF.
- R11: Masked status equals raw status AND mask. `irq` is the OR of the masked status. A mask of zero holds `irq` low.
- R12: A write to the clear register clears only the bits written as 1. An event in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and all counters |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | 8 | Byte address; must be word-aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Combined masked interrupt |

## Verification
A channel whose count, prescale phase or state is wrong raises `irq` on the wrong clock. The error shows at the first zero arrival, within load+1 prescaled ticks of the starting write. A reload value applied too early, or not at all, shifts the second event but not the first, so each repeat check times two consecutive events. A machine stuck in HALT, or one that fails to reach it, shows as a missing event after a rearm, or as a second event where none may appear. Status bits left stale or cleared wrongly show up on the next status read and on `irq` in the same cycle.

// File: rtl/qt_pkg.sv
package qt_pkg;

    localparam int CFG_W      = 8;
    localparam int BIT_RUN    = 7;
    localparam int BIT_REPEAT = 6;
    localparam int BIT_PS_HI  = 3;
    localparam int BIT_PS_LO  = 2;
    localparam int BIT_WIDE   = 1;
    localparam int BIT_SINGLE = 0;

    // word index inside a channel window
    localparam logic [1:0] SUB_LOAD   = 2'd0;
    localparam logic [1:0] SUB_VALUE  = 2'd1;
    localparam logic [1:0] SUB_CTRL   = 2'd2;
    localparam logic [1:0] SUB_RELOAD = 2'd3;

    // word index inside the shared window
    localparam logic [1:0] SUB_IEN  = 2'd0;
    localparam logic [1:0] SUB_IRAW = 2'd1;
    localparam logic [1:0] SUB_IACT = 2'd2;
    localparam logic [1:0] SUB_IACK = 2'd3;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_HALT  = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_SINGLE = 2'd2
    } ch_mode_e;

    function automatic ch_mode_e mode_of(input logic [CFG_W-1:0] c);
        if (c[BIT_SINGLE])      return MODE_SINGLE;
        else if (c[BIT_REPEAT]) return MODE_REPEAT;
        else                    return MODE_FREE;
    endfunction

endpackage

// File: rtl/qt_prescale.sv
module qt_prescale #(
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PRE_W = HI_LOG;
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << MID_LOG) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << HI_LOG) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (sel)
            2'b00:   limit = '0;
            2'b01:   limit = LIM_MID;
            default: limit = LIM_HI;
        endcase
    end

    assign tick = run && !restart && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)              pre_q <= '0;
        else if (restart || !run) pre_q <= '0;
        else if (tick)           pre_q <= '0;
        else                     pre_q <= pre_q + PRE_W'(1);
    end

    // R4: a divider above one never yields ticks on adjacent clocks
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> !tick);

endmodule

// File: rtl/qt_channel.sv
module qt_channel
    import qt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int MID_LOG  = 4,
    parameter int HI_LOG   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_cfg,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             evt_o
);
    localparam int HIGH_W = CNT_W - NARROW_W;

    ch_state_e        state_q, state_d;
    ch_mode_e         mode;
    logic [CNT_W-1:0] cnt_q, cnt_d, view, reload_q;
    logic [CFG_W-1:0] cfg_q;
    logic             tick, run, restart;

    assign mode    = mode_of(cfg_q);
    assign run     = (state_q == CH_COUNT);
    assign restart = wr_load || wr_cfg;
    assign view    = cfg_q[BIT_WIDE] ? cnt_q
                                     : {{HIGH_W{1'b0}}, cnt_q[NARROW_W-1:0]};

    qt_prescale #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .sel     (cfg_q[BIT_PS_HI:BIT_PS_LO]),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (wr_cfg && wdata[BIT_RUN]) state_d = CH_COUNT;        // start
            end
            CH_COUNT: begin
                if (wr_cfg && !wdata[BIT_RUN]) state_d = CH_OFF;         // stop
                else if (tick && mode == MODE_SINGLE && view <= CNT_W'(1))
                    state_d = CH_HALT;                                   // expire
            end
            CH_HALT: begin
                if (wr_cfg && !wdata[BIT_RUN]) state_d = CH_OFF;         // stop
                else if (wr_load)              state_d = CH_COUNT;       // rearm
            end
            default: state_d = CH_OFF;
        endcase
    end

    // counter datapath and event output
    always_comb begin
        cnt_d = cnt_q;
        evt_o = 1'b0;
        if (wr_load) begin
            cnt_d = wdata;
        end else if (tick) begin
            if (view == '0) begin
                unique case (mode)
                    MODE_REPEAT: cnt_d = reload_q;
                    MODE_FREE:   cnt_d = '1;
                    default:     cnt_d = cnt_q;
                endcase
            end else begin
                cnt_d = view - CNT_W'(1);
                evt_o = (view == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            cfg_q    <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_load || wr_reload) reload_q <= wdata;
            if (wr_cfg)               cfg_q    <= wdata[CFG_W-1:0];
        end
    end

    assign value_o  = view;
    assign reload_o = reload_q;
    assign cfg_o    = cfg_q;

    // R6: a finished single-shot count does not move until rearmed
    a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !wr_load) |=> $stable(cnt_q));

    // R6: no further event once halted
    a_r6_no_event_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT) |-> !evt_o);

    // R7: repeat wrap picks up the buffered reload value
    a_r7_reload_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_REPEAT && view == '0) |=> (cnt_q == $past(reload_q)));

    // R9: free-running wrap lands on all ones of the active width
    a_r9_wrap_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_FREE && view == '0) |=> (&value_o[NARROW_W-1:0]));

endmodule

// File: rtl/qt_irq.sv
module qt_irq #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt,
    input  logic            wr_en,
    input  logic            wr_ack,
    input  logic [N_CH-1:0] wdata,
    output logic [N_CH-1:0] en_o,
    output logic [N_CH-1:0] raw_o,
    output logic [N_CH-1:0] act_o,
    output logic            irq_o
);
    logic [N_CH-1:0] en_q, raw_q, ack_bits;

    assign ack_bits = wr_ack ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            raw_q <= '0;
        end else begin
            if (wr_en) en_q <= wdata;
            raw_q <= (raw_q & ~ack_bits) | evt;
        end
    end

    assign en_o  = en_q;
    assign raw_o = raw_q;
    assign act_o = raw_q & en_q;
    assign irq_o = |act_o;

    // R12: an event survives a clear in the same cycle
    a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw_o & $past(evt)) == $past(evt)));

    // R12: acknowledged bits without a fresh event are cleared
    a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((raw_o & $past(wdata & ~evt)) == '0));

endmodule

// File: rtl/quad_timer.sv
module quad_timer
    import qt_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 8,
    parameter int MID_LOG  = 4,
    parameter int HI_LOG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              irq
);
    localparam int WIN_W = ADDR_W - 4;

    logic             wr_cyc, aligned;
    logic [WIN_W-1:0] win;
    logic [1:0]       sub;

    logic [N_CH-1:0]  evt, en_bits, raw_bits, act_bits;
    logic [N_CH-1:0]  wr_load, wr_cfg, wr_reload;
    logic             wr_ien, wr_iack;

    logic [CNT_W-1:0] ch_val    [N_CH];
    logic [CNT_W-1:0] ch_reload [N_CH];
    logic [CFG_W-1:0] ch_cfg    [N_CH];

    assign wr_cyc  = psel && penable && pwrite;
    assign aligned = (paddr[1:0] == 2'b00);
    assign win     = paddr[ADDR_W-1:4];
    assign sub     = paddr[3:2];

    assign wr_ien  = wr_cyc && aligned && win == '0 && sub == SUB_IEN;
    assign wr_iack = wr_cyc && aligned && win == '0 && sub == SUB_IACK;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            logic hit;
            assign hit           = wr_cyc && aligned && (win == WIN_W'(ch + 1));
            assign wr_load[ch]   = hit && sub == SUB_LOAD;
            assign wr_cfg[ch]    = hit && sub == SUB_CTRL;
            assign wr_reload[ch] = hit && sub == SUB_RELOAD;

            qt_channel #(
                .CNT_W    (CNT_W),
                .NARROW_W (NARROW_W),
                .MID_LOG  (MID_LOG),
                .HI_LOG   (HI_LOG)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_load   (wr_load[ch]),
                .wr_cfg    (wr_cfg[ch]),
                .wr_reload (wr_reload[ch]),
                .wdata     (pwdata),
                .value_o   (ch_val[ch]),
                .reload_o  (ch_reload[ch]),
                .cfg_o     (ch_cfg[ch]),
                .evt_o     (evt[ch])
            );
        end
    endgenerate

    qt_irq #(.N_CH(N_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .wr_en  (wr_ien),
        .wr_ack (wr_iack),
        .wdata  (pwdata[N_CH-1:0]),
        .en_o   (en_bits),
        .raw_o  (raw_bits),
        .act_o  (act_bits),
        .irq_o  (irq)
    );

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (win == '0) begin
                unique case (sub)
                    SUB_IEN:  prdata = CNT_W'(en_bits);
                    SUB_IRAW: prdata = CNT_W'(raw_bits);
                    SUB_IACT: prdata = CNT_W'(act_bits);
                    default:  prdata = '0;
                endcase
            end
            for (int ch = 0; ch < N_CH; ch++) begin
                if (win == WIN_W'(ch + 1)) begin
                    unique case (sub)
                        SUB_LOAD:  prdata = ch_reload[ch];
                        SUB_VALUE: prdata = ch_val[ch];
                        SUB_CTRL:  prdata = CNT_W'(ch_cfg[ch]);
                        default:   prdata = ch_reload[ch];
                    endcase
                end
            end
        end
    end

endmodule

// File: tb/quad_timer_bench.sv
module quad_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    quad_timer u_quad_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    // irq must stay low for n-1 negedges and be high at the n-th
    task automatic expect_irq_at(input int n, input string tag);
        int early = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k < n && irq && early == 0) early = k;
        end
        check({tag, " no early irq"}, 32'(early), 32'd0);
        check({tag, " irq on time"}, {31'd0, irq}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 irq low", {31'd0, irq}, 32'd0);
        rd_chk("R1 mask", 8'h00, 32'h0);
        rd_chk("R1 raw", 8'h04, 32'h0);
        rd_chk("R1 masked", 8'h08, 32'h0);
        rd_chk("R1 ch0 value", 8'h14, 32'h0);
        rd_chk("R1 ch3 control", 8'h48, 32'h0);
    endtask

    task automatic t_map;
        wr(8'h30, 32'h0000_1234);
        repeat (5) @(negedge clk);
        rd_chk("R3 disabled holds", 8'h34, 32'h0000_1234);
        rd_chk("R2 load readback", 8'h30, 32'h0000_1234);
        wr(8'h38, 32'h0000_000C);
        rd_chk("R2 control readback", 8'h38, 32'h0000_000C);
        wr(8'h38, 32'h0);
    endtask

    task automatic t_single;
        wr(8'h00, 32'h2);
        wr(8'h20, 32'd4);
        wr(8'h28, 32'hC3);                 // single-shot wins over repeat
        expect_irq_at(4, "R6 single");
        rd_chk("R5 raw bit", 8'h04, 32'h2);
        wr(8'h0C, 32'h2);
        repeat (20) @(negedge clk);
        check("R6 one event only", {31'd0, irq}, 32'd0);
        rd_chk("R6 stays at zero", 8'h24, 32'h0);
        wr(8'h20, 32'd2);
        expect_irq_at(2, "R6 rearm");
        wr(8'h0C, 32'h2);
    endtask

    task automatic t_coincide;
        wr(8'h20, 32'd3);                  // event lands on the clear's edge
        wr(8'h0C, 32'h2);
        rd_chk("R12 event beats clear", 8'h04, 32'h2);
        wr(8'h0C, 32'h2);
        rd_chk("R12 later clear", 8'h04, 32'h0);
    endtask

    task automatic t_repeat;
        wr(8'h00, 32'h1);
        wr(8'h10, 32'd9);
        wr(8'h18, 32'hC2);
        expect_irq_at(9, "R7 first");
        wr(8'h0C, 32'h1);
        expect_irq_at(7, "R7 period");
        wr(8'h18, 32'h0);
        wr(8'h0C, 32'h1);
    endtask

    task automatic t_reload;
        wr(8'h00, 32'h8);
        wr(8'h40, 32'd20);
        wr(8'h48, 32'hC2);
        wr(8'h4C, 32'd5);
        expect_irq_at(17, "R8 current count kept");
        wr(8'h0C, 32'h8);
        expect_irq_at(3, "R8 new period");
        wr(8'h48, 32'h0);
        wr(8'h0C, 32'h8);
    endtask

    task automatic t_free;
        wr(8'h30, 32'h0001_0002);
        rd_chk("R10 upper bits hidden", 8'h34, 32'h0000_0002);
        wr(8'h38, 32'h80);
        @(negedge clk);
        rd_chk("R10 R9 narrow wrap", 8'h34, 32'h0000_FFFF);
        wr(8'h38, 32'h0);
        wr(8'h30, 32'd1);
        wr(8'h38, 32'h82);
        rd_chk("R9 wide wrap", 8'h34, 32'hFFFF_FFFF);
        wr(8'h38, 32'h0);
    endtask

    task automatic t_mask;
        wr(8'h00, 32'h0);
        check("R11 mask zero quiet", {31'd0, irq}, 32'd0);
        rd_chk("R11 masked zero", 8'h08, 32'h0);
        rd_chk("R11 raw kept", 8'h04, 32'h4);
        wr(8'h00, 32'h4);
        check("R11 irq raised", {31'd0, irq}, 32'd1);
        rd_chk("R11 masked bit", 8'h08, 32'h4);
        wr(8'h0C, 32'h1);
        rd_chk("R12 other bit kept", 8'h04, 32'h4);
        wr(8'h0C, 32'h4);
        check("R12 irq after clear", {31'd0, irq}, 32'd0);
        rd_chk("R12 raw cleared", 8'h04, 32'h0);
    endtask

    task automatic t_prescale;
        wr(8'h00, 32'h2);
        wr(8'h28, 32'h87);
        wr(8'h20, 32'd3);
        expect_irq_at(48, "R4 div16");
        wr(8'h0C, 32'h2);
        wr(8'h28, 32'h8B);
        wr(8'h20, 32'd1);
        expect_irq_at(256, "R4 div256");
        wr(8'h0C, 32'h2);
        wr(8'h28, 32'h8F);
        wr(8'h20, 32'd1);
        expect_irq_at(256, "R4 code11");
        wr(8'h0C, 32'h2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_single();
        t_coincide();
        t_repeat();
        t_reload();
        t_free();
        t_mask();
        t_prescale();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule